// File: doc/BRIEF.md
# Application Processor Power State Sequencer

This block is a hardware state machine that takes an application processor through its off, standby, suspend and run states. It watches two active-low status lines from the processor: one that says the processor is held in reset and one that says it is asleep. Both lines pass through two-flop synchronizers. From them it decodes an observed state. Reset dominates: an asserted reset line means off, whatever the sleep line says. It moves through short transition states toward the observed state.

On power-up it releases the system reset line, pulses the PMIC enable line low and then waits a bounded time for the processor to leave reset. If the processor does not come out of reset in that window, the machine falls back to off. A forced shutdown pulls both open-drain outputs low and keeps PMIC enable low for a long hold window; a power-on request ends that hold early. All delays count milliseconds, and one millisecond is a parameter-set number of pulses on a free-running tick input. The current state goes out as a 4-bit code, with a one-cycle strobe whenever the code changes.

Top module: `ap_power_seq`

## Requirements
- R1: The observed state is off when `ap_rst_ind_n` is 0, whatever `ap_sleep_ind_n` is. It is suspend when `ap_rst_ind_n` is 1 and `ap_sleep_ind_n` is 0, and run when both are 1. Both inputs pass through two synchronizing flops before the decode.
- R2: After reset, `state_code` is 0 (off), `sys_rst_od` is 0, `pmic_en_od` is 1 and `state_valid` is 0.
- R3: From off, an observed state other than off or a `pwr_on_req` pulse moves the machine to off-to-standby (code 4), then standby (code 1), then standby-to-suspend (code 5), one cycle each.
- R4: On entry to standby-to-suspend, `sys_rst_od` is released to 1. After SETTLE_MS, `pmic_en_od` goes to 0 for PULSE_MS and then returns to 1.
- R5: After the pulse, the machine waits up to REL_WAIT_MS for the reset line to deassert. On timeout it goes to standby-to-off (code 9) and then off (code 0).
- R6: When the reset line deasserts inside that window, the machine waits a further BOOT_MS and then enters suspend (code 2).
- R7: From suspend, an observed run state leads to suspend-to-run (code 6). The machine enters run (code 3) once the reset line has stayed deasserted for STABLE_MS. If that has not happened within RESUME_MS, it fires a forced shutdown and goes to run-to-suspend (code 7).
- R8: From run, any observed state other than run goes to run-to-suspend (code 7) and then suspend (code 2). From suspend, an observed off state goes to suspend-to-standby (code 8), then standby-to-off (code 9), then off (code 0), without passing through standby.
- R9: A forced shutdown (`force_off_req`, or the R7 timeout) drives `sys_rst_od` and `pmic_en_od` to 0 one cycle later and does not change the state by itself. `pmic_en_od` stays 0 for HOLD_MS. `sys_rst_od` stays 0 until the next standby-to-suspend entry.
- R10: `pwr_on_req` during a forced hold releases `pmic_en_od` to 1 one cycle later.
- R11: `state_valid` is 1 for exactly the cycles in which `state_code` shows a value different from the cycle before.
- R12: One millisecond is TICKS_PER_MS pulses of `ms_tick`. While `ms_tick` is held low, no timed phase advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | Free-running timing pulse |
| ap_rst_ind_n | input | 1 | Processor-in-reset status, active low, asynchronous |
| ap_sleep_ind_n | input | 1 | Processor-in-sleep status, active low, asynchronous |
| pwr_on_req | input | 1 | Power-on request pulse |
| force_off_req | input | 1 | Forced shutdown request pulse |
| sys_rst_od | output | 1 | Open-drain system reset level (0 = pull low) |
| pmic_en_od | output | 1 | Open-drain PMIC enable level (0 = pull low) |
| state_code | output | 4 | Current state code |
| state_valid | output | 1 | One-cycle strobe on each state change |

## Verification
The hardest situation to reach is the resume timeout. Suspend-to-run is only entered when the processor reports run, so the reset line must fall again after that entry and before it has been stable for STABLE_MS. The stimulus raises the sleep line to get into suspend-to-run and pulls the reset line low two cycles later, inside the stability window. It then follows the forced shutdown through to off and measures the length of the PMIC hold. A separate step holds the tick low in the middle of a power-up to show that every timed phase freezes.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
   typedef enum logic [3:0] {
      ST_G3   = 4'd0,
      ST_S5   = 4'd1,
      ST_S3   = 4'd2,
      ST_S0   = 4'd3,
      ST_G3S5 = 4'd4,
      ST_S5S3 = 4'd5,
      ST_S3S0 = 4'd6,
      ST_S0S3 = 4'd7,
      ST_S3S5 = 4'd8,
      ST_S5G3 = 4'd9
   } pstate_e;

   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_PULSE  = 2'd1,
      PH_WAIT   = 2'd2,
      PH_BOOT   = 2'd3
   } phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pseq_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg_q[s] <= RST_VAL;
            else if (s == 0) stg_q[s] <= d_async;
            else             stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/pseq_ms_timer.sv
module pseq_ms_timer #(
   parameter int TICKS_PER_MS = 1,
   parameter int CW           = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          clear,
   output logic [CW-1:0] ms_cnt,
   output logic          ms_stb
);
   generate
      if (TICKS_PER_MS < 1) begin : g_bad_tpm
         $error("TICKS_PER_MS must be at least one");
      end
      if (TICKS_PER_MS == 1) begin : g_direct
         assign ms_stb = tick;
      end else begin : g_prescale
         localparam int PW = $clog2(TICKS_PER_MS);
         localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clear) pre_q <= '0;
            else if (tick)  pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
         end
         assign ms_stb = tick && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ms_cnt <= '0;
      else if (clear)                     ms_cnt <= '0;
      else if (ms_stb && (ms_cnt != '1))  ms_cnt <= ms_cnt + 1'b1;
   end

   p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ms_cnt == '0));
   p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear) |=> $stable(ms_cnt));
endmodule

// File: rtl/ap_power_seq.sv
module ap_power_seq
   import pseq_pkg::*;
#(
   parameter int TICKS_PER_MS = 1,
   parameter int SYNC_STAGES  = 2,
   parameter int SETTLE_MS    = 50,
   parameter int PULSE_MS     = 50,
   parameter int REL_WAIT_MS  = 300,
   parameter int BOOT_MS      = 500,
   parameter int RESUME_MS    = 1000,
   parameter int STABLE_MS    = 1,
   parameter int HOLD_MS      = 9000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       ap_rst_ind_n,
   input  logic       ap_sleep_ind_n,
   input  logic       pwr_on_req,
   input  logic       force_off_req,
   output logic       sys_rst_od,
   output logic       pmic_en_od,
   output logic [3:0] state_code,
   output logic       state_valid
);
   localparam int MAX_MS = max2(max2(max2(SETTLE_MS, PULSE_MS), max2(REL_WAIT_MS, BOOT_MS)),
                                max2(max2(RESUME_MS, STABLE_MS), HOLD_MS));
   localparam int CW = $clog2(MAX_MS + 2);

   generate
      if (SETTLE_MS < 1 || PULSE_MS < 1 || REL_WAIT_MS < 1 || BOOT_MS < 1 ||
          RESUME_MS < 1 || STABLE_MS < 1 || HOLD_MS < 1) begin : g_bad_delay
         $error("all delays must be at least one millisecond");
      end
      if (STABLE_MS >= RESUME_MS) begin : g_bad_window
         $error("STABLE_MS must be shorter than RESUME_MS");
      end
   endgenerate

   // status synchronizers: bit 1 = reset line, bit 0 = sleep line
   logic [1:0] sync_q;
   pseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async({ap_rst_ind_n, ap_sleep_ind_n}),
      .q_sync (sync_q)
   );
   logic rst_free, slp_free;
   assign rst_free = sync_q[1];
   assign slp_free = sync_q[0];

   logic obs_off, obs_run;
   assign obs_off = !rst_free;
   assign obs_run = rst_free && slp_free;

   pstate_e state_q, state_n;
   phase_e  phase_q, phase_n;
   logic    seq_clear, force_fire, resume_to;
   logic [CW-1:0] seq_ms, hold_ms, stab_q;
   logic    seq_stb, hold_stb;
   logic    sys_rst_q, hold_q, valid_q;

   assign seq_clear  = (state_n != state_q) || (phase_n != phase_q);
   assign resume_to  = (state_q == ST_S3S0) && (state_n == ST_S0S3);
   assign force_fire = force_off_req || resume_to;

   pseq_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) u_seq_tmr (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .clear(seq_clear),
      .ms_cnt(seq_ms), .ms_stb(seq_stb)
   );
   pseq_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) u_hold_tmr (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .clear(force_fire),
      .ms_cnt(hold_ms), .ms_stb(hold_stb)
   );

   always_comb begin
      state_n = state_q;
      phase_n = phase_q;
      unique case (state_q)
         ST_G3:   if (!obs_off || pwr_on_req) state_n = ST_G3S5;
         ST_G3S5: state_n = ST_S5;
         ST_S5: begin
            state_n = ST_S5S3;
            phase_n = PH_SETTLE;
         end
         ST_S5S3: begin
            unique case (phase_q)
               PH_SETTLE: if (seq_ms >= CW'(SETTLE_MS)) phase_n = PH_PULSE;
               PH_PULSE:  if (seq_ms >= CW'(PULSE_MS))  phase_n = PH_WAIT;
               PH_WAIT: begin
                  if (rst_free)                           phase_n = PH_BOOT;
                  else if (seq_ms >= CW'(REL_WAIT_MS))    state_n = ST_S5G3;
               end
               PH_BOOT:   if (seq_ms >= CW'(BOOT_MS))   state_n = ST_S3;
               default:   phase_n = PH_SETTLE;
            endcase
         end
         ST_S3: begin
            if (obs_off)      state_n = ST_S3S5;
            else if (obs_run) state_n = ST_S3S0;
         end
         ST_S3S0: begin
            if (stab_q >= CW'(STABLE_MS))        state_n = ST_S0;
            else if (seq_ms >= CW'(RESUME_MS))   state_n = ST_S0S3;
         end
         ST_S0:   if (!obs_run) state_n = ST_S0S3;
         ST_S0S3: state_n = ST_S3;
         ST_S3S5: state_n = ST_S5G3;
         ST_S5G3: state_n = ST_G3;
         default: state_n = ST_G3;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_G3;
         phase_q   <= PH_SETTLE;
         valid_q   <= 1'b0;
         stab_q    <= '0;
         sys_rst_q <= 1'b0;
         hold_q    <= 1'b0;
      end else begin
         state_q <= state_n;
         phase_q <= phase_n;
         valid_q <= (state_n != state_q);
         if (state_q != ST_S3S0 || !rst_free) stab_q <= '0;
         else if (seq_stb && stab_q != '1)    stab_q <= stab_q + 1'b1;
         if (force_fire)             sys_rst_q <= 1'b0;
         else if (state_q == ST_S5)  sys_rst_q <= 1'b1;
         if (force_fire)             hold_q <= 1'b0 | 1'b1;
         else if (pwr_on_req || state_q == ST_S5 || hold_ms >= CW'(HOLD_MS))
                                     hold_q <= 1'b0;
      end
   end

   assign sys_rst_od  = sys_rst_q;
   assign pmic_en_od  = !(hold_q || (state_q == ST_S5S3 && phase_q == PH_PULSE));
   assign state_code  = state_q;
   assign state_valid = valid_q;

   p_off_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_G3 && !rst_free && !pwr_on_req) |=> (state_q == ST_G3));
   p_g3_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_G3) |=> (state_q == ST_G3 || state_q == ST_G3S5));
   p_s5_onward_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S5) |=> (state_q == ST_S5S3 && sys_rst_od));
   p_rst_up_in_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S5S3 && phase_q == PH_PULSE && !force_off_req) |=> sys_rst_od);
   p_run_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_S0) |=> (state_q != ST_S0 || $past(state_q) == ST_S3S0));
   p_skip_s5_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S3S5) |=> (state_q == ST_S5G3));
   p_force_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |=> (!sys_rst_od && !pmic_en_od));
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on_req && !force_off_req && !resume_to) |=> pmic_en_od);
   p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_code) |-> state_valid);
endmodule

// File: tb/ap_power_seq_bench.sv
module ap_power_seq_bench;
   localparam int TPM = 3;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b1;
   logic rst_in = 1'b0, slp_in = 1'b1, pwr_on = 1'b0, force_off = 1'b0;
   logic sys_rst_od, pmic_en_od, state_valid;
   logic [3:0] state_code;
   int n_tests = 0, n_fail = 0;

   always #4 clk = ~clk;

   ap_power_seq #(
      .TICKS_PER_MS(TPM), .SETTLE_MS(4), .PULSE_MS(5), .REL_WAIT_MS(20),
      .BOOT_MS(6), .RESUME_MS(15), .STABLE_MS(2), .HOLD_MS(30)
   ) u_ap_power_seq (
      .clk(clk), .rst_n(rst_n), .ms_tick(tick_en),
      .ap_rst_ind_n(rst_in), .ap_sleep_ind_n(slp_in),
      .pwr_on_req(pwr_on), .force_off_req(force_off),
      .sys_rst_od(sys_rst_od), .pmic_en_od(pmic_en_od),
      .state_code(state_code), .state_valid(state_valid)
   );

   // monitor: logs codes on each strobe, tallies strobe mismatches (R11)
   logic [3:0] log_v [64];
   int log_n = 0, strobe_bad = 0;
   logic [3:0] prev_code = 4'd0;
   always @(negedge clk) begin
      if (rst_n) begin
         if ((state_code != prev_code) != state_valid) strobe_bad++;
         if (state_valid && log_n < 64) begin
            log_v[log_n] = state_code;
            log_n++;
         end
      end
      prev_code = state_code;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_on();
      pwr_on = 1'b1; cyc(1); pwr_on = 1'b0;
   endtask

   // checks the logged codes from index base against a sequence
   task automatic check_log(input int base, input logic [3:0] exp [6], input int len, input string req);
      for (int i = 0; i < len; i++) begin
         int idx = base + i;
         int a = (idx < log_n) ? int'(log_v[idx]) : -1;
         check(a == int'(exp[i]), req, a, int'(exp[i]));
      end
   endtask

   // table: {reset line, sleep line, expected state code}
   typedef struct packed { logic r; logic s; logic [3:0] code; } vec_t;
   localparam vec_t VTAB [8] = '{
      '{1'b0, 1'b1, 4'd0}, '{1'b0, 1'b0, 4'd0}, '{1'b1, 1'b0, 4'd2}, '{1'b1, 1'b1, 4'd3},
      '{1'b1, 1'b0, 4'd2}, '{1'b1, 1'b1, 4'd3}, '{1'b0, 1'b1, 4'd0}, '{1'b1, 1'b1, 4'd3}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [3:0] seq [6];
      int base, cnt, lowlen;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R2 reset state
      check(state_code == 4'd0, "R2 state", state_code, 0);
      check(sys_rst_od == 1'b0, "R2 sys_rst", sys_rst_od, 0);
      check(pmic_en_od == 1'b1, "R2 pmic", pmic_en_od, 1);
      check(state_valid == 1'b0, "R2 valid", state_valid, 0);

      // R1/R6/R7/R8 table walk
      for (int i = 0; i < 8; i++) begin
         rst_in = VTAB[i].r; slp_in = VTAB[i].s;
         cyc(250);
         check(state_code == VTAB[i].code, $sformatf("R1 R8 row %0d state", i), state_code, VTAB[i].code);
         check(pmic_en_od == 1'b1, $sformatf("R6 row %0d pmic", i), pmic_en_od, 1);
      end

      // R8 run to off path
      base = log_n;
      rst_in = 1'b0; cyc(40);
      seq = '{4'd7, 4'd2, 4'd8, 4'd9, 4'd0, 4'd0};
      check_log(base, seq, 5, "R8 path to off");

      // R3 R4 R5 power-up that times out
      base = log_n;
      pwr_on = 1'b1; cnt = 0;
      cyc(1); pwr_on = 1'b0;
      while (pmic_en_od && cnt < 60) begin cyc(1); cnt++; end
      check(cnt >= 12 && cnt <= 17, "R4 settle before pulse", cnt, 14);
      check(sys_rst_od == 1'b1, "R4 reset released", sys_rst_od, 1);
      lowlen = 0;
      while (!pmic_en_od && lowlen < 60) begin cyc(1); lowlen++; end
      check(lowlen >= 14 && lowlen <= 18, "R4 pulse length", lowlen, 16);
      cyc(80);
      seq = '{4'd4, 4'd1, 4'd5, 4'd9, 4'd0, 4'd0};
      check_log(base, seq, 5, "R3 R5 timeout path");

      // R7 resume timeout -> forced shutdown, R9 hold
      rst_in = 1'b1; slp_in = 1'b0; cyc(150);
      check(state_code == 4'd2, "R6 reach suspend", state_code, 2);
      base = log_n;
      slp_in = 1'b1; cyc(2); rst_in = 1'b0;
      cnt = 0;
      while (pmic_en_od && cnt < 100) begin cyc(1); cnt++; end
      check(sys_rst_od == 1'b0, "R9 timeout reset low", sys_rst_od, 0);
      lowlen = 0;
      while (!pmic_en_od && lowlen < 200) begin cyc(1); lowlen++; end
      check(lowlen >= 88 && lowlen <= 94, "R9 hold length", lowlen, 91);
      check(sys_rst_od == 1'b0, "R9 reset stays low", sys_rst_od, 0);
      seq = '{4'd6, 4'd7, 4'd2, 4'd8, 4'd9, 4'd0};
      check_log(base, seq, 6, "R7 timeout path");

      // R9 R10 forced hold released by power-on request
      force_off = 1'b1; cyc(1); force_off = 1'b0;
      check(pmic_en_od == 1'b0 && sys_rst_od == 1'b0, "R9 force outputs", pmic_en_od, 0);
      cyc(10);
      check(state_code == 4'd0, "R9 state unchanged", state_code, 0);
      check(pmic_en_od == 1'b0, "R9 hold active", pmic_en_od, 0);
      pulse_on();
      check(pmic_en_od == 1'b1, "R10 early release", pmic_en_od, 1);
      cyc(150);
      check(state_code == 4'd0, "R5 back to off", state_code, 0);

      // R9 force while running keeps the state
      rst_in = 1'b1; slp_in = 1'b1; cyc(200);
      check(state_code == 4'd3, "R7 reach run", state_code, 3);
      force_off = 1'b1; cyc(1); force_off = 1'b0; cyc(4);
      check(!sys_rst_od && !pmic_en_od, "R9 force in run", {sys_rst_od, pmic_en_od}, 0);
      check(state_code == 4'd3, "R9 run state kept", state_code, 3);
      rst_in = 1'b0; cyc(200);
      check(state_code == 4'd0, "R8 off after force", state_code, 0);

      // R12 tick held low freezes timed phases
      tick_en = 1'b0;
      pulse_on(); cyc(100);
      check(state_code == 4'd5, "R12 frozen in power-up", state_code, 5);
      check(pmic_en_od == 1'b1, "R12 no pulse without tick", pmic_en_od, 1);
      tick_en = 1'b1; cyc(150);
      check(state_code == 4'd0, "R12 resumes to off", state_code, 0);

      // R11 strobe tally
      check(strobe_bad == 0, "R11 strobe mismatches", strobe_bad, 0);
      check(log_n > 20, "R11 strobes seen", log_n, 21);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule